// File: doc/BRIEF.md
# Synchronous Offset and FIFO Gross-Error Monitor

This block watches a parallel SCSI controller during synchronous transfers. It keeps two counts. The first is the outstanding REQ/ACK offset: the number of REQ pulses that no ACK has answered yet. The second is the occupancy of the synchronous data FIFO. From these counts and from the strobes that change them, it finds six protocol violations. Any violation raises one sticky gross-error flag. A 3-bit cause code records which violation came first.

Software reads the status through a read strobe. The read clears the flag and the cause on the next clock. The block has no data path: it sees only strobes, the role of the controller (initiator or target) and the programmed maximum offset. It returns the two counts and the error status, all as registers.

Top module: `sync_offset_monitor`

## Requirements
- R1: A synchronous active-high reset clears the offset count, the FIFO occupancy, the gross-error flag and the cause code to zero. Every output changes on the clock edge after the inputs that cause the change.
- R2: When the maximum offset is nonzero, a REQ strobe alone adds one to the offset count and an ACK strobe alone subtracts one. This holds in both roles. A REQ and an ACK in the same cycle leave the count unchanged. The count never goes below zero.
- R3: A maximum offset of zero selects asynchronous operation. In that mode the offset count is held at zero and no offset violation (causes 3, 4 and 5) is raised.
- R4: An offset overflow sets the flag with cause 4 and leaves the count unchanged. It occurs when a REQ strobe alone arrives while the count is already at or above the maximum offset.
- R5: In target mode, an ACK strobe alone while the count is zero sets the flag with cause 3. In initiator mode, the same event raises nothing and the count stays at zero.
- R6: A phase-change strobe clears the offset count. In initiator mode, a phase change while the count is nonzero also sets the flag with cause 5. In target mode, a phase change raises nothing.
- R7: A pop alone while the FIFO is empty sets the flag with cause 1 and leaves the occupancy at zero.
- R8: A push alone while the FIFO holds FIFO_DEPTH bytes sets the flag with cause 2 and leaves the occupancy at FIFO_DEPTH.
- R9: A push and a pop in the same cycle leave the occupancy unchanged and raise no error.
- R10: A transfer-start strobe with the synchronous-receive tag low, while the occupancy is nonzero, sets the flag with cause 6. A start tagged as synchronous receive never raises this error.
- R11: Once the flag is set, it and the cause hold until a status read, even if later violations occur. When several violations occur in one cycle, the lowest cause code is recorded.
- R12: A status read clears the flag and the cause on the next edge. If a violation occurs in the same cycle as the read, the flag stays set and takes that violation's cause instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_stb | input | 1 | One-cycle strobe for a REQ edge |
| ack_stb | input | 1 | One-cycle strobe for an ACK edge |
| is_target | input | 1 | 1 = target role, 0 = initiator role |
| max_offset | input | OFS_W | Programmed maximum synchronous offset; 0 = asynchronous |
| phase_stb | input | 1 | Bus phase-change strobe |
| fifo_push | input | 1 | A byte is written into the synchronous FIFO |
| fifo_pop | input | 1 | A byte is read from the synchronous FIFO |
| xfer_start | input | 1 | A new transfer begins |
| xfer_sync_rx | input | 1 | Tag for xfer_start: 1 = synchronous data receive |
| stat_rd | input | 1 | Status read; clears the flag and the cause |
| offset_cnt | output | OFS_W | Outstanding offset count |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | FIFO occupancy |
| err_cause | output | 3 | First cause since the last clear (0 = none) |
| gross_err | output | 1 | Sticky gross-error flag |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. This lets a few pushes reach the full boundary, so the overflow and the same-cycle push/pop case on a full FIFO can be checked directly. The offset width stays at its default of 5 bits. The bench then programs the maximum offset at run time: 0 for the asynchronous case, 2 so the overflow boundary is reached in two REQs, and 8 for plain counting.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  localparam int CAUSE_W   = 3;
  localparam int NUM_CAUSE = 6;

  // Cause codes; a lower value wins when several occur together.
  typedef enum logic [CAUSE_W-1:0] {
    C_NONE     = 3'd0,
    C_DATA_UNF = 3'd1,
    C_DATA_OVF = 3'd2,
    C_OFS_UNF  = 3'd3,
    C_OFS_OVF  = 3'd4,
    C_PHASE    = 3'd5,
    C_RESIDUE  = 3'd6
  } cause_e;
endpackage

// File: rtl/sgm_offset_track.sv
module sgm_offset_track #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_stb,
  input  logic             ack_stb,
  input  logic             is_target,
  input  logic             phase_stb,
  input  logic [OFS_W-1:0] max_offset,
  output logic [OFS_W-1:0] cnt,
  output logic             ovf_viol,
  output logic             unf_viol,
  output logic             phs_viol
);
  logic sync_mode, inc, dec;

  assign sync_mode = (max_offset != '0);
  assign inc       = req_stb & ~ack_stb;
  assign dec       = ack_stb & ~req_stb;

  always_comb begin
    ovf_viol = sync_mode & inc & (cnt >= max_offset);
    unf_viol = sync_mode & is_target & dec & (cnt == '0);
    phs_viol = sync_mode & ~is_target & phase_stb & (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !sync_mode || phase_stb)
      cnt <= '0;
    else if (inc && !ovf_viol)
      cnt <= cnt + 1'b1;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  // R3
  async_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (max_offset == '0) |=> (cnt == '0));

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_viol && !phase_stb) |=> (cnt == $past(cnt)));

  // R6
  phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
    phase_stb |=> (cnt == '0));
endmodule

// File: rtl/sgm_fifo_level.sv
module sgm_fifo_level #(
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             xfer_start,
  input  logic             xfer_sync_rx,
  output logic [LVL_W-1:0] level,
  output logic             dunf_viol,
  output logic             dovf_viol,
  output logic             resid_viol
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  logic only_push, only_pop;
  assign only_push = push & ~pop;
  assign only_pop  = pop & ~push;

  always_comb begin
    dunf_viol  = only_pop & (level == '0);
    dovf_viol  = only_push & (level == FULL);
    resid_viol = xfer_start & ~xfer_sync_rx & (level != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)
      level <= '0;
    else if (only_push && !dovf_viol)
      level <= level + 1'b1;
    else if (only_pop && !dunf_viol)
      level <= level - 1'b1;
  end

  // R8
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL);

  // R9
  push_pop_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(level));
endmodule

// File: rtl/sgm_err_collect.sv
module sgm_err_collect
  import sgm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CAUSE:1]   viol,
  input  logic                 stat_rd,
  output logic                 flag,
  output logic [CAUSE_W-1:0]   cause
);
  logic               any_viol;
  logic [CAUSE_W-1:0] first_code;

  assign any_viol = |viol;

  // Scan from the highest code down, so the lowest set code is kept.
  always_comb begin
    first_code = C_NONE;
    for (int i = NUM_CAUSE; i >= 1; i--)
      if (viol[i]) first_code = CAUSE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      cause <= C_NONE;
    end else if (any_viol && (!flag || stat_rd)) begin
      flag  <= 1'b1;
      cause <= first_code;
    end else if (stat_rd) begin
      flag  <= 1'b0;
      cause <= C_NONE;
    end
  end

  // R11
  sticky_first_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_rd) |=> (flag && $stable(cause)));

  // R12
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !any_viol) |=> (!flag && cause == C_NONE));

  // R1
  idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (cause == C_NONE));
endmodule

// File: rtl/sync_offset_monitor.sv
module sync_offset_monitor
  import sgm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int OFS_W      = 5,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_stb,
  input  logic               ack_stb,
  input  logic               is_target,
  input  logic [OFS_W-1:0]   max_offset,
  input  logic               phase_stb,
  input  logic               fifo_push,
  input  logic               fifo_pop,
  input  logic               xfer_start,
  input  logic               xfer_sync_rx,
  input  logic               stat_rd,
  output logic [OFS_W-1:0]   offset_cnt,
  output logic [LVL_W-1:0]   fifo_level,
  output logic [CAUSE_W-1:0] err_cause,
  output logic               gross_err
);
  logic ovf_v, unf_v, phs_v, dunf_v, dovf_v, resid_v;
  logic [NUM_CAUSE:1] viol;

  sgm_offset_track #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .req_stb(req_stb), .ack_stb(ack_stb),
    .is_target(is_target), .phase_stb(phase_stb), .max_offset(max_offset),
    .cnt(offset_cnt), .ovf_viol(ovf_v), .unf_viol(unf_v), .phs_viol(phs_v)
  );

  sgm_fifo_level #(.FIFO_DEPTH(FIFO_DEPTH)) u_lvl (
    .clk(clk), .rst(rst), .push(fifo_push), .pop(fifo_pop),
    .xfer_start(xfer_start), .xfer_sync_rx(xfer_sync_rx),
    .level(fifo_level), .dunf_viol(dunf_v), .dovf_viol(dovf_v),
    .resid_viol(resid_v)
  );

  always_comb begin
    viol                = '0;
    viol[int'(C_DATA_UNF)] = dunf_v;
    viol[int'(C_DATA_OVF)] = dovf_v;
    viol[int'(C_OFS_UNF)]  = unf_v;
    viol[int'(C_OFS_OVF)]  = ovf_v;
    viol[int'(C_PHASE)]    = phs_v;
    viol[int'(C_RESIDUE)]  = resid_v;
  end

  sgm_err_collect u_err (
    .clk(clk), .rst(rst), .viol(viol), .stat_rd(stat_rd),
    .flag(gross_err), .cause(err_cause)
  );

  // R2
  ofs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (max_offset != '0 && !phase_stb && req_stb && ack_stb)
      |=> $stable(offset_cnt));
endmodule

// File: tb/test_sync_offset_monitor.sv
module test_sync_offset_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_stb = 0, ack_stb = 0, is_target = 0, phase_stb = 0;
  logic [4:0] max_offset = '0;
  logic       fifo_push = 0, fifo_pop = 0, xfer_start = 0, xfer_sync_rx = 0;
  logic       stat_rd = 0;
  logic [4:0] offset_cnt;
  logic [2:0] fifo_level;
  logic [2:0] err_cause;
  logic       gross_err;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_offset_monitor #(.FIFO_DEPTH(DEPTH), .OFS_W(5)) i_sync_offset_monitor (
    .clk(clk), .rst(rst), .req_stb(req_stb), .ack_stb(ack_stb),
    .is_target(is_target), .max_offset(max_offset), .phase_stb(phase_stb),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .xfer_start(xfer_start),
    .xfer_sync_rx(xfer_sync_rx), .stat_rd(stat_rd),
    .offset_cnt(offset_cnt), .fifo_level(fifo_level),
    .err_cause(err_cause), .gross_err(gross_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    req_stb = 0; ack_stb = 0; phase_stb = 0; fifo_push = 0; fifo_pop = 0;
    xfer_start = 0; xfer_sync_rx = 0; stat_rd = 0; rst = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, int ofs, int lvl, int flg, int cs);
    chk({req, " offset"}, int'(offset_cnt), ofs);
    chk({req, " level"},  int'(fifo_level), lvl);
    chk({req, " flag"},   int'(gross_err),  flg);
    chk({req, " cause"},  int'(err_cause),  cs);
  endtask

  task automatic clear_status();
    stat_rd = 1; tick();
  endtask

  task automatic t_reset();
    rst = 1; tick();
    chk_all("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_count();
    max_offset = 5'd8; is_target = 0;
    req_stb = 1; tick(); req_stb = 1; tick(); req_stb = 1; tick();
    chk_all("R2 three REQ", 3, 0, 0, 0);
    ack_stb = 1; tick();
    chk_all("R2 ACK", 2, 0, 0, 0);
    req_stb = 1; ack_stb = 1; tick();
    chk_all("R2 REQ+ACK", 2, 0, 0, 0);
    is_target = 1;
    req_stb = 1; tick();
    chk_all("R2 target REQ", 3, 0, 0, 0);
    ack_stb = 1; tick();
    chk_all("R2 target ACK", 2, 0, 0, 0);
    phase_stb = 1; tick();
    chk_all("R6 target phase", 0, 0, 0, 0);
  endtask

  task automatic t_async();
    max_offset = 5'd0; is_target = 0;
    req_stb = 1; tick(); req_stb = 1; tick();
    chk_all("R3 async REQ", 0, 0, 0, 0);
    is_target = 1; ack_stb = 1; tick();
    chk_all("R3 async target ACK", 0, 0, 0, 0);
    is_target = 0;
  endtask

  task automatic t_ofs_ovf();
    max_offset = 5'd2; is_target = 0;
    req_stb = 1; tick(); req_stb = 1; tick();
    chk_all("R4 at max", 2, 0, 0, 0);
    req_stb = 1; tick();
    chk_all("R4 overflow", 2, 0, 1, 4);
    clear_status();
    chk_all("R12 read clear", 2, 0, 0, 0);
  endtask

  task automatic t_ofs_unf();
    is_target = 1; phase_stb = 1; tick();
    chk_all("R6 target phase clear", 0, 0, 0, 0);
    ack_stb = 1; tick();
    chk_all("R5 target underflow", 0, 0, 1, 3);
    clear_status();
    is_target = 0; ack_stb = 1; tick();
    chk_all("R5 initiator ACK at zero", 0, 0, 0, 0);
  endtask

  task automatic t_phase();
    is_target = 0; req_stb = 1; tick();
    chk_all("R6 one REQ", 1, 0, 0, 0);
    phase_stb = 1; tick();
    chk_all("R6 initiator phase", 0, 0, 1, 5);
    clear_status();
  endtask

  task automatic t_fifo();
    fifo_pop = 1; tick();
    chk_all("R7 pop empty", 0, 0, 1, 1);
    clear_status();
    for (int i = 0; i < DEPTH; i++) begin fifo_push = 1; tick(); end
    chk_all("R8 fill", 0, DEPTH, 0, 0);
    fifo_push = 1; tick();
    chk_all("R8 push full", 0, DEPTH, 1, 2);
    clear_status();
    fifo_push = 1; fifo_pop = 1; tick();
    chk_all("R9 push+pop full", 0, DEPTH, 0, 0);
    fifo_pop = 1; tick();
    chk_all("R9 pop", 0, DEPTH-1, 0, 0);
  endtask

  task automatic t_resid();
    xfer_start = 1; xfer_sync_rx = 1; tick();
    chk_all("R10 sync rx start", 0, DEPTH-1, 0, 0);
    xfer_start = 1; xfer_sync_rx = 0; tick();
    chk_all("R10 residue", 0, DEPTH-1, 1, 6);
    clear_status();
    for (int i = 0; i < DEPTH-1; i++) begin fifo_pop = 1; tick(); end
    xfer_start = 1; tick();
    chk_all("R10 empty start", 0, 0, 0, 0);
  endtask

  task automatic t_sticky();
    fifo_pop = 1; tick();
    is_target = 1; ack_stb = 1; tick();
    chk_all("R11 first kept", 0, 0, 1, 1);
    clear_status();
    fifo_pop = 1; ack_stb = 1; tick();
    chk_all("R11 lowest wins", 0, 0, 1, 1);
    clear_status();
    chk_all("R11 cleared", 0, 0, 0, 0);
  endtask

  task automatic t_rdclr();
    is_target = 1; ack_stb = 1; tick();
    chk_all("R12 setup", 0, 0, 1, 3);
    stat_rd = 1; fifo_pop = 1; tick();
    chk_all("R12 read with new", 0, 0, 1, 1);
    clear_status();
    chk_all("R12 read", 0, 0, 0, 0);
    is_target = 0;
  endtask

  task automatic t_midreset();
    max_offset = 5'd8;
    req_stb = 1; fifo_push = 1; tick();
    fifo_push = 1; tick();
    xfer_start = 1; tick();
    chk_all("R1 before reset", 1, 2, 1, 6);
    rst = 1; tick();
    chk_all("R1 mid reset", 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_count();
    t_async();
    t_ofs_ovf();
    t_ofs_unf();
    t_phase();
    t_fifo();
    t_resid();
    t_sticky();
    t_rdclr();
    t_midreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule